// File: doc/BRIEF.md
# Video Formatter Test-Access Port

This block gives a host bus indirect access to a small bank of factory test registers inside a video formatter. The host writes a test register number to an index port. Later accesses to a separate data port then reach the register that number selects. The index stays put across data accesses, so the host can poll one register repeatedly without rewriting it.

Three registers are read-only observation points on the formatter's datapath:
- the last byte sent on the pixel bus toward the colour palette DAC;
- the last byte received from video RAM;
- the last 16-colour intermediate value produced by the formatting logic.

Each one is captured on its bus strobe. One write-only control register drives two outputs: a software-held reset for the rest of the device, and a global output disable. Only the external reset pin clears that control register.

The host read path is combinational from the address, so read data follows the address in the same cycle. Writes take effect at the clock edge on which the write strobe is sampled high. The external reset is asserted asynchronously and released synchronously inside the block.

Top module: `vfx_test_port`

## Requirements
- R1: A write to the index port (address 0x19) stores the 8-bit value, and a read of the index port returns it. The stored index is unchanged by any number of data-port reads or writes.
- R2: With index 1 selected, a read of the data port (address 0x18) returns the byte present on `pix_data_i` in the most recent cycle in which `pix_stb_i` was high.
- R3: With index 2 selected, a read of the data port returns the byte present on `vram_data_i` in the most recent cycle in which `vram_stb_i` was high.
- R4: With index 3 selected, a read of the data port returns the 4-bit value last captured from `c16_data_i` on `c16_stb_i`, in bits 3:0, with bits 7:4 reading zero.
- R5: With index 0, 4, or any value from 5 to 255 selected, a read of the data port returns 0x00.
- R6: A data-port write while the index is anything other than 4 changes no register and no output.
- R7: A data-port write with index 4 sets the software reset from bit 0 of the write data. While that bit is 1, `dev_rst_no` is low from the next cycle on; writing 0 releases it.
- R8: A data-port write with index 4 sets the output disable from bit 1 of the write data. While that bit is 1, `out_en_o` is low; writing 0 raises it again. Bits 7:2 of that write are ignored.
- R9: Asserting `rst_ni` clears the index, all three captures and both control bits, and holds `dev_rst_no` low. The software reset does not clear the control register, the index or the captures.
- R10: A host access to any address other than 0x18 or 0x19 reads 0x00, and a write to such an address is ignored.
- R11: A capture keeps its value in every cycle in which its strobe is low, whatever its data bus carries.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | External reset, active low, asynchronous assert |
| host_addr_i | input | 8 | Host port address |
| host_wr_i | input | 1 | Host write strobe, sampled on the clock edge |
| host_wdata_i | input | 8 | Host write data |
| host_rdata_o | output | 8 | Host read data for the addressed port |
| pix_data_i | input | 8 | Pixel byte toward the palette DAC |
| pix_stb_i | input | 1 | Pixel byte valid |
| vram_data_i | input | 8 | Byte received from video RAM |
| vram_stb_i | input | 1 | Video RAM byte valid |
| c16_data_i | input | 4 | 16-colour intermediate value |
| c16_stb_i | input | 1 | 16-colour value valid |
| dev_rst_no | output | 1 | Reset to the rest of the device, active low |
| out_en_o | output | 1 | Global output enable, low disables device outputs |

## Verification
The assertions check every cycle that:
- each capture loads on its strobe and otherwise holds;
- a control write shows up on the reset and enable outputs in the next cycle;
- data-port writes to other indices leave those outputs untouched;
- the unimplemented and write-only indices read back zero.

Only the bench scenarios can show that the index survives repeated data accesses, and that the software reset leaves the captures and the control register intact while the external pin clears them. They also cover the full sweep of indices and data values through the read mux.

// File: rtl/vfx_pkg.sv
package vfx_pkg;
  localparam int unsigned DATA_W = 8;

  typedef enum logic [DATA_W-1:0] {
    TREG_NONE = 8'd0,
    TREG_PIX  = 8'd1,
    TREG_VRAM = 8'd2,
    TREG_C16  = 8'd3,
    TREG_CTRL = 8'd4
  } treg_e;

  localparam int unsigned NUM_CAP = 3;
  localparam int unsigned CAP_PIX  = 0;
  localparam int unsigned CAP_VRAM = 1;
  localparam int unsigned CAP_C16  = 2;

  localparam int unsigned CTRL_HOLD_BIT = 0;
  localparam int unsigned CTRL_DIS_BIT  = 1;
endpackage

// File: rtl/vfx_rst_sync.sv
module vfx_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  output logic rst_no
);
  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sync_q <= '0;
    else         sync_q <= sync_d;
  end

  assign rst_no = sync_q[STAGES-1];
endmodule

// File: rtl/vfx_capture.sv
module vfx_capture #(
  parameter int unsigned W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         stb_i,
  input  logic [W-1:0] data_i,
  output logic [W-1:0] data_o
);
  logic [W-1:0] cap_q;
  logic [W-1:0] cap_d;

  always_comb begin
    cap_d = cap_q;
    if (stb_i) cap_d = data_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cap_q <= '0;
    else         cap_q <= cap_d;
  end

  assign data_o = cap_q;

  // R2 / R3 / R4: a strobed byte is what the latch holds one cycle later
  p_load_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stb_i |=> data_o == $past(data_i));

  p_hold_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !stb_i |=> $stable(data_o));
endmodule

// File: rtl/vfx_index_reg.sv
module vfx_index_reg #(
  parameter int unsigned W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         wr_en_i,
  input  logic [W-1:0] wdata_i,
  output logic [W-1:0] idx_o
);
  logic [W-1:0] idx_q;
  logic [W-1:0] idx_d;

  always_comb begin
    idx_d = idx_q;
    if (wr_en_i) idx_d = wdata_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) idx_q <= '0;
    else         idx_q <= idx_d;
  end

  assign idx_o = idx_q;

  p_keep_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_en_i |=> $stable(idx_o));
endmodule

// File: rtl/vfx_ctrl_reg.sv
module vfx_ctrl_reg (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       wr_en_i,
  input  logic [1:0] wdata_i,
  output logic       hold_o,
  output logic       dis_o
);
  import vfx_pkg::*;

  logic hold_q, hold_d;
  logic dis_q,  dis_d;

  always_comb begin
    hold_d = hold_q;
    dis_d  = dis_q;
    if (wr_en_i) begin
      hold_d = wdata_i[CTRL_HOLD_BIT];
      dis_d  = wdata_i[CTRL_DIS_BIT];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hold_q <= 1'b0;
      dis_q  <= 1'b0;
    end else begin
      hold_q <= hold_d;
      dis_q  <= dis_d;
    end
  end

  assign hold_o = hold_q;
  assign dis_o  = dis_q;
endmodule

// File: rtl/vfx_test_port.sv
module vfx_test_port #(
  parameter int unsigned ADDR_W    = 8,
  parameter int unsigned C16_W     = 4,
  parameter int unsigned IDX_ADDR  = 'h19,
  parameter int unsigned DAT_ADDR  = 'h18,
  parameter int unsigned RST_STAGES = 2
) (
  input  logic                      clk_i,
  input  logic                      rst_ni,
  input  logic [ADDR_W-1:0]         host_addr_i,
  input  logic                      host_wr_i,
  input  logic [vfx_pkg::DATA_W-1:0] host_wdata_i,
  output logic [vfx_pkg::DATA_W-1:0] host_rdata_o,
  input  logic [vfx_pkg::DATA_W-1:0] pix_data_i,
  input  logic                      pix_stb_i,
  input  logic [vfx_pkg::DATA_W-1:0] vram_data_i,
  input  logic                      vram_stb_i,
  input  logic [C16_W-1:0]          c16_data_i,
  input  logic                      c16_stb_i,
  output logic                      dev_rst_no,
  output logic                      out_en_o
);
  import vfx_pkg::*;

  localparam int unsigned PAD_W = DATA_W - C16_W;
  localparam logic [ADDR_W-1:0] IDX_A = ADDR_W'(IDX_ADDR);
  localparam logic [ADDR_W-1:0] DAT_A = ADDR_W'(DAT_ADDR);

  logic rst_sync_n;
  logic sel_idx, sel_dat;
  logic idx_wr_en, ctrl_wr_en;
  logic [DATA_W-1:0] idx_q;
  logic hold_q, dis_q;

  logic [DATA_W-1:0] cap_in  [NUM_CAP];
  logic              cap_stb [NUM_CAP];
  logic [DATA_W-1:0] cap_out [NUM_CAP];

  vfx_rst_sync #(.STAGES(RST_STAGES)) u_rst (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .rst_no(rst_sync_n)
  );

  // address decode
  always_comb begin
    sel_idx    = (host_addr_i == IDX_A);
    sel_dat    = (host_addr_i == DAT_A);
    idx_wr_en  = host_wr_i && sel_idx;
    ctrl_wr_en = host_wr_i && sel_dat && (idx_q == DATA_W'(TREG_CTRL));
  end

  vfx_index_reg #(.W(DATA_W)) u_idx (
    .clk_i  (clk_i),
    .rst_ni (rst_sync_n),
    .wr_en_i(idx_wr_en),
    .wdata_i(host_wdata_i),
    .idx_o  (idx_q)
  );

  vfx_ctrl_reg u_ctrl (
    .clk_i  (clk_i),
    .rst_ni (rst_sync_n),
    .wr_en_i(ctrl_wr_en),
    .wdata_i(host_wdata_i[1:0]),
    .hold_o (hold_q),
    .dis_o  (dis_q)
  );

  // capture channel inputs
  always_comb begin
    cap_in[CAP_PIX]   = pix_data_i;
    cap_stb[CAP_PIX]  = pix_stb_i;
    cap_in[CAP_VRAM]  = vram_data_i;
    cap_stb[CAP_VRAM] = vram_stb_i;
    cap_in[CAP_C16]   = {{PAD_W{1'b0}}, c16_data_i};
    cap_stb[CAP_C16]  = c16_stb_i;
  end

  for (genvar g = 0; g < NUM_CAP; g++) begin : g_cap
    vfx_capture #(.W(DATA_W)) u_cap (
      .clk_i (clk_i),
      .rst_ni(rst_sync_n),
      .stb_i (cap_stb[g]),
      .data_i(cap_in[g]),
      .data_o(cap_out[g])
    );
  end

  // host read mux
  always_comb begin
    host_rdata_o = '0;
    if (sel_idx) begin
      host_rdata_o = idx_q;
    end else if (sel_dat) begin
      case (idx_q)
        DATA_W'(TREG_PIX):  host_rdata_o = cap_out[CAP_PIX];
        DATA_W'(TREG_VRAM): host_rdata_o = cap_out[CAP_VRAM];
        DATA_W'(TREG_C16):  host_rdata_o = cap_out[CAP_C16];
        default:            host_rdata_o = '0;
      endcase
    end
  end

  assign dev_rst_no = rst_sync_n && !hold_q;
  assign out_en_o   = !dis_q;

  p_swrst_r7: assert property (@(posedge clk_i) disable iff (!rst_sync_n)
    (host_wr_i && host_addr_i == DAT_A && idx_q == DATA_W'(TREG_CTRL))
      |=> dev_rst_no == !$past(host_wdata_i[0]));

  p_oe_r8: assert property (@(posedge clk_i) disable iff (!rst_sync_n)
    (host_wr_i && host_addr_i == DAT_A && idx_q == DATA_W'(TREG_CTRL))
      |=> out_en_o == !$past(host_wdata_i[1]));

  p_ignore_r6: assert property (@(posedge clk_i) disable iff (!rst_sync_n)
    (host_wr_i && host_addr_i == DAT_A && idx_q != DATA_W'(TREG_CTRL))
      |=> ($stable(out_en_o) && $stable(dev_rst_no)));

  p_rdzero_r5: assert property (@(posedge clk_i) disable iff (!rst_sync_n)
    (host_addr_i == DAT_A &&
     (idx_q == DATA_W'(TREG_NONE) || idx_q >= DATA_W'(TREG_CTRL)))
      |-> host_rdata_o == '0);

  p_other_r10: assert property (@(posedge clk_i) disable iff (!rst_sync_n)
    (host_addr_i != DAT_A && host_addr_i != IDX_A) |-> host_rdata_o == '0);
endmodule

// File: tb/vfx_test_port_test.sv
module vfx_test_port_test;
  logic       clk_i = 1'b0;
  logic       rst_ni;
  logic [7:0] host_addr_i;
  logic       host_wr_i;
  logic [7:0] host_wdata_i;
  logic [7:0] host_rdata_o;
  logic [7:0] pix_data_i;
  logic       pix_stb_i;
  logic [7:0] vram_data_i;
  logic       vram_stb_i;
  logic [3:0] c16_data_i;
  logic       c16_stb_i;
  logic       dev_rst_no;
  logic       out_en_o;

  int n_chk  = 0;
  int n_fail = 0;
  int cycles = 0;

  localparam logic [7:0] A_IDX = 8'h19;
  localparam logic [7:0] A_DAT = 8'h18;

  vfx_test_port uut (
    .clk_i(clk_i), .rst_ni(rst_ni),
    .host_addr_i(host_addr_i), .host_wr_i(host_wr_i),
    .host_wdata_i(host_wdata_i), .host_rdata_o(host_rdata_o),
    .pix_data_i(pix_data_i), .pix_stb_i(pix_stb_i),
    .vram_data_i(vram_data_i), .vram_stb_i(vram_stb_i),
    .c16_data_i(c16_data_i), .c16_stb_i(c16_stb_i),
    .dev_rst_no(dev_rst_no), .out_en_o(out_en_o)
  );

  always #4 clk_i = ~clk_i;

  task automatic chk(input string req, input int got, input int exp);
    n_chk++;
    if (got != exp) begin
      n_fail++;
      $display("FAIL %s: got 0x%0h expected 0x%0h", req, got, exp);
    end
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    forever begin
      @(posedge clk_i);
      cycles++;
      if (cycles > 150000) begin
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: got %0d cycles expected fewer", cycles);
        finish_run();
      end
    end
  end

  task automatic wr(input logic [7:0] a, input logic [7:0] d);
    @(negedge clk_i);
    host_addr_i  = a;
    host_wdata_i = d;
    host_wr_i    = 1'b1;
    @(negedge clk_i);
    host_wr_i    = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [7:0] d);
    host_addr_i = a;
    #1;
    d = host_rdata_o;
  endtask

  task automatic strobe(input logic [7:0] p, input logic [7:0] v, input logic [3:0] c);
    @(negedge clk_i);
    pix_data_i = p; vram_data_i = v; c16_data_i = c;
    pix_stb_i = 1'b1; vram_stb_i = 1'b1; c16_stb_i = 1'b1;
    @(negedge clk_i);
    pix_stb_i = 1'b0; vram_stb_i = 1'b0; c16_stb_i = 1'b0;
  endtask

  function automatic int exp_dat(int idx, int p, int v, int c);
    if (idx == 1) return p;
    if (idx == 2) return v;
    if (idx == 3) return c & 15;
    return 0;
  endfunction

  task automatic do_reset();
    @(negedge clk_i);
    rst_ni = 1'b0;
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    repeat (3) @(negedge clk_i);
  endtask

  logic [7:0] r, r2;

  initial begin
    rst_ni = 1'b0;
    host_addr_i = 8'h00; host_wr_i = 1'b0; host_wdata_i = 8'h00;
    pix_data_i = 8'h00; pix_stb_i = 1'b0;
    vram_data_i = 8'h00; vram_stb_i = 1'b0;
    c16_data_i = 4'h0; c16_stb_i = 1'b0;
    repeat (3) @(negedge clk_i);
    // R9: reset state
    chk("R9 dev reset low in reset", dev_rst_no, 0);
    chk("R9 outputs enabled in reset", out_en_o, 1);
    rst_ni = 1'b1;
    repeat (3) @(negedge clk_i);
    chk("R9 dev reset released", dev_rst_no, 1);
    rd(A_IDX, r); chk("R9 index cleared", r, 0);
    for (int k = 1; k <= 3; k++) begin
      wr(A_IDX, 8'(k));
      rd(A_DAT, r); chk("R9 capture cleared", r, 0);
    end

    // R1 R5 R6: sweep every index
    strobe(8'hA5, 8'h3C, 4'h9);
    for (int i = 0; i < 256; i++) begin
      wr(A_IDX, 8'(i));
      rd(A_IDX, r); chk("R1 index readback", r, i);
      rd(A_DAT, r);  chk("R5 data read by index", r, exp_dat(i, 'hA5, 'h3C, 'h9));
      rd(A_DAT, r2); chk("R1 repeated read same reg", r2, r);
      if (i != 4) begin
        wr(A_DAT, 8'hFF);
        chk("R6 reset unaffected", dev_rst_no, 1);
        chk("R6 enable unaffected", out_en_o, 1);
        rd(A_IDX, r); chk("R1 index kept after data write", r, i);
        rd(A_DAT, r); chk("R6 register unchanged", r, exp_dat(i, 'hA5, 'h3C, 'h9));
      end
    end

    // R2 R3 R4: sweep capture data
    for (int v = 0; v < 256; v++) begin
      strobe(8'(v), 8'(255 - v), 4'(v * 7));
      wr(A_IDX, 8'd1); rd(A_DAT, r); chk("R2 pixel capture", r, v);
      wr(A_IDX, 8'd2); rd(A_DAT, r); chk("R3 vram capture", r, 255 - v);
      wr(A_IDX, 8'd3); rd(A_DAT, r); chk("R4 16-colour capture", r, (v * 7) & 15);
    end

    // R11: data moves without strobes
    strobe(8'h42, 8'h24, 4'h6);
    for (int j = 0; j < 16; j++) begin
      @(negedge clk_i);
      pix_data_i = 8'(j * 17); vram_data_i = 8'(~j); c16_data_i = 4'(j);
    end
    wr(A_IDX, 8'd1); rd(A_DAT, r); chk("R11 pixel held", r, 'h42);
    wr(A_IDX, 8'd2); rd(A_DAT, r); chk("R11 vram held", r, 'h24);
    wr(A_IDX, 8'd3); rd(A_DAT, r); chk("R11 16-colour held", r, 'h6);

    // R7 R8: control register
    wr(A_IDX, 8'd4);
    for (int w = 0; w < 4; w++) begin
      wr(A_DAT, 8'(w) | 8'hF0);
      chk("R7 software reset", dev_rst_no, (w & 1) ? 0 : 1);
      chk("R8 output disable", out_en_o, (w & 2) ? 0 : 1);
      rd(A_DAT, r); chk("R5 control reads zero", r, 0);
    end
    wr(A_DAT, 8'hFC);
    chk("R8 upper bits ignored rst", dev_rst_no, 1);
    chk("R8 upper bits ignored oe", out_en_o, 1);

    // R10: other addresses
    wr(8'h20, 8'h03);
    chk("R10 write ignored rst", dev_rst_no, 1);
    chk("R10 write ignored oe", out_en_o, 1);
    rd(A_IDX, r); chk("R10 index kept", r, 4);
    rd(8'h20, r); chk("R10 other address reads zero", r, 0);

    // R9: software reset keeps state, pin clears it
    wr(A_DAT, 8'h03);
    strobe(8'h5A, 8'hC3, 4'hE);
    wr(A_IDX, 8'd1); rd(A_DAT, r); chk("R9 capture kept in sw reset", r, 'h5A);
    chk("R9 sw reset still held", dev_rst_no, 0);
    chk("R9 disable still held", out_en_o, 0);
    do_reset();
    chk("R9 pin clears hold", dev_rst_no, 1);
    chk("R9 pin clears disable", out_en_o, 1);
    rd(A_IDX, r); chk("R9 pin clears index", r, 0);
    wr(A_IDX, 8'd1); rd(A_DAT, r); chk("R9 pin clears capture", r, 0);

    finish_run();
  end
endmodule